// File: doc/BRIEF.md
# Pipelined Burst Memory Cycle Controller

This block is the control and storage core of a synchronous memory with four-word bursts. On each rising clock edge it looks at two active-low address strobes, three chip-select inputs, a burst step strobe and a set of write controls. From these it classifies the cycle as a deselect, a new burst, a burst step or a burst pause, and as a read or a write. Each stored word is made of byte lanes. A lane is eight data bits plus one parity bit.

The processor strobe only takes effect when the active-low chip enable is low, and it always starts a read. The controller strobe can start either a read or a write. A global write input overrides the per-lane write inputs. The per-lane write inputs only count while a gate input is low. Within a burst, the two low address bits follow either a linear or an exclusive-or order, and the order wraps after four words. Read data passes through an address register and an output register. A separate output-enable flag tells the pad whether to drive. That flag is gated at once by an asynchronous output-enable input.

Top module: `burst_sram_core`

## Requirements
- R1: The block is selected only when `chip_en_n`=0, `sel_hi`=1 and `sel_lo_n`=0. A strobe that takes effect while the block is not selected is a deselect: nothing is written and no data is driven.
- R2: When `chip_en_n`=1, `proc_stb_n` is ignored. In that case `ctl_stb_n`=0 deselects the block, and `ctl_stb_n`=1 lets the current burst go on.
- R3: A burst started by `proc_stb_n`=0 (with `chip_en_n`=0) is always a read, whatever the write inputs are. In the next cycle without a strobe, the write inputs are obeyed again.
- R4: A burst started by `ctl_stb_n`=0 is a write if `all_wr_n`=0, or if `lane_gate_n`=0 and any bit of `lane_wr_n` is 0. Otherwise it is a read.
- R5: `all_wr_n`=0 writes every lane, whatever `lane_gate_n` and `lane_wr_n` are. `lane_gate_n`=1 blocks `lane_wr_n`. Several lanes may be written at once.
- R6: Lane n is held in `wdata`/`rdata` bits [8n+7:8n] plus parity bit 8*LANES+n.
- R7: A new burst uses `addr_i`. Step k (k=0..3) uses the same upper bits, with low two bits equal to (base+k) mod 4 when `order_xor`=0, or base XOR k when `order_xor`=1. After the fourth word the sequence wraps to the base.
- R8: In a cycle with no strobe during an active burst, `step_n`=0 moves to the next burst address and `step_n`=1 repeats the current one. The cycle reads or writes according to the write inputs. After reset or a deselect, cycles with no strobe neither read nor write.
- R9: A read taken at edge k drives `rdata` with `rdata_oe`=1 (when `out_en_n`=0) from edge k+1 until edge k+2.
- R10: `out_en_n`=1 forces `rdata_oe`=0 without waiting for a clock. The data slot of a write cycle (after edge k+1) is never driven.
- R11: A deselect at edge k leaves `rdata_oe`=0 after edge k+1.
- R12: After reset no burst is active and `rdata_oe`=0.
- R13: Write data on `wdata` is captured on the edge that decides the write. It is stored at that cycle's address, which is the new address on a burst start and the burst address otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| addr_i | input | ADDR_W | Word address taken on a burst start |
| proc_stb_n | input | 1 | Processor address strobe, active low, gated by `chip_en_n` |
| ctl_stb_n | input | 1 | Controller address strobe, active low |
| step_n | input | 1 | Burst step, active low; high pauses the burst |
| chip_en_n | input | 1 | Active-low chip enable |
| sel_hi | input | 1 | Active-high chip select |
| sel_lo_n | input | 1 | Active-low chip select |
| all_wr_n | input | 1 | Global write, active low |
| lane_gate_n | input | 1 | Gate for the per-lane writes, active low |
| lane_wr_n | input | LANES | Per-lane write, active low |
| order_xor | input | 1 | Burst order: 0 linear, 1 exclusive-or |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| wdata | input | 9*LANES | Write data |
| rdata | output | 9*LANES | Registered read data |
| rdata_oe | output | 1 | Pad drive enable for `rdata` |

## Verification
The bench builds the block with ADDR_W=5 and LANES=4. This gives a 32-word array, so bursts can start at every low-bit offset, in several different quartets, including the top one. All four lanes plus their parity bits can then be checked for exact placement. The small depth lets the bench keep a full reference copy of the array. A write to the wrong address therefore shows up when any later read returns the wrong data.

// File: rtl/bsc_pkg.sv
package bsc_pkg;

  typedef enum logic [2:0] {
    CYC_IDLE,
    CYC_DESEL,
    CYC_START,
    CYC_NEXT,
    CYC_HOLD
  } cyc_kind_e;

  function automatic logic [1:0] burst_lo(input logic [1:0] base,
                                          input logic [1:0] stepc,
                                          input logic       use_xor);
    return use_xor ? (base ^ stepc) : (base + stepc);
  endfunction

endpackage

// File: rtl/bsc_decode.sv
module bsc_decode
  import bsc_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             proc_stb_n,
  input  logic             ctl_stb_n,
  input  logic             step_n,
  input  logic             chip_en_n,
  input  logic             sel_hi,
  input  logic             sel_lo_n,
  input  logic             all_wr_n,
  input  logic             lane_gate_n,
  input  logic [LANES-1:0] lane_wr_n,
  input  logic             burst_act,
  output cyc_kind_e        kind,
  output logic [LANES-1:0] lane_we,
  output logic             wr,
  output logic             rd
);

  logic             selected;
  logic             proc_go;
  logic             wr_ok;
  logic [LANES-1:0] lane_req;

  always_comb begin
    selected = !chip_en_n && sel_hi && !sel_lo_n;
    proc_go  = !proc_stb_n && !chip_en_n;
    if (!all_wr_n)        lane_req = '1;
    else if (!lane_gate_n) lane_req = ~lane_wr_n;
    else                   lane_req = '0;

    kind  = CYC_IDLE;
    wr_ok = 1'b0;
    if (proc_go) begin
      kind = selected ? CYC_START : CYC_DESEL;
    end else if (!ctl_stb_n) begin
      kind  = selected ? CYC_START : CYC_DESEL;
      wr_ok = selected;
    end else if (burst_act) begin
      kind  = step_n ? CYC_HOLD : CYC_NEXT;
      wr_ok = 1'b1;
    end
  end

  assign lane_we = wr_ok ? lane_req : '0;
  assign wr      = |lane_we;
  assign rd      = ((kind == CYC_START) || (kind == CYC_NEXT) || (kind == CYC_HOLD)) && !wr;

  assert_proc_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!proc_stb_n && !chip_en_n) |-> !wr);

  assert_global_all_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !all_wr_n) |-> (&lane_we));

  assert_gate_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && all_wr_n) |-> !lane_gate_n);

  assert_desel_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!(sel_hi && !sel_lo_n) && !ctl_stb_n) |-> !wr);

endmodule

// File: rtl/bsc_burst.sv
module bsc_burst
  import bsc_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  cyc_kind_e         kind,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              order_xor,
  output logic              burst_act,
  output logic [ADDR_W-1:0] cyc_addr
);

  localparam int HI_W = ADDR_W - 2;

  logic [ADDR_W-1:0] base_q, base_d;
  logic [1:0]        cnt_q, cnt_d;
  logic              act_q, act_d;
  logic [1:0]        stepc;

  always_comb begin
    stepc = (kind == CYC_NEXT) ? cnt_q + 2'd1 : cnt_q;
    if (kind == CYC_START) cyc_addr = addr_i;
    else cyc_addr = {base_q[ADDR_W-1 -: HI_W], burst_lo(base_q[1:0], stepc, order_xor)};
  end

  always_comb begin
    base_d = base_q;
    cnt_d  = cnt_q;
    act_d  = act_q;
    unique case (kind)
      CYC_START: begin
        base_d = addr_i;
        cnt_d  = 2'd0;
        act_d  = 1'b1;
      end
      CYC_NEXT:  cnt_d = cnt_q + 2'd1;
      CYC_DESEL: act_d = 1'b0;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      cnt_q  <= 2'd0;
      act_q  <= 1'b0;
    end else begin
      base_q <= base_d;
      cnt_q  <= cnt_d;
      act_q  <= act_d;
    end
  end

  assign burst_act = act_q;

  assert_pause_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == CYC_HOLD) |=> ($stable(cnt_q) && $stable(base_q)));

  assert_desel_ends_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == CYC_DESEL) |=> !burst_act);

endmodule

// File: rtl/bsc_array.sv
module bsc_array #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [LANES-1:0]     lane_we,
  input  logic [9*LANES-1:0]   wdata,
  input  logic                 rd,
  output logic [9*LANES-1:0]   q,
  output logic                 q_vld
);

  localparam int DEPTH = 1 << ADDR_W;
  localparam int W     = 9 * LANES;
  localparam int PBASE = 8 * LANES;

  logic [W-1:0]      mem [DEPTH];
  logic [ADDR_W-1:0] raddr_q;
  logic              pend_q;
  logic              vld_q;
  logic [W-1:0]      q_q;

  always_ff @(posedge clk) begin
    for (int n = 0; n < LANES; n++) begin
      if (lane_we[n]) begin
        mem[addr][8*n +: 8]  <= wdata[8*n +: 8];
        mem[addr][PBASE + n] <= wdata[PBASE + n];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raddr_q <= '0;
      pend_q  <= 1'b0;
      vld_q   <= 1'b0;
    end else begin
      if (rd) raddr_q <= addr;
      pend_q <= rd;
      vld_q  <= pend_q;
    end
  end

  always_ff @(posedge clk) begin
    if (pend_q) q_q <= mem[raddr_q];
  end

  assign q     = q_q;
  assign q_vld = vld_q;

  assert_two_stage_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rd |=> ##1 q_vld);

endmodule

// File: rtl/burst_sram_core.sv
module burst_sram_core
  import bsc_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic                 proc_stb_n,
  input  logic                 ctl_stb_n,
  input  logic                 step_n,
  input  logic                 chip_en_n,
  input  logic                 sel_hi,
  input  logic                 sel_lo_n,
  input  logic                 all_wr_n,
  input  logic                 lane_gate_n,
  input  logic [LANES-1:0]     lane_wr_n,
  input  logic                 order_xor,
  input  logic                 out_en_n,
  input  logic [9*LANES-1:0]   wdata,
  output logic [9*LANES-1:0]   rdata,
  output logic                 rdata_oe
);

  logic [1:0]        rst_sync_q;
  logic              core_rst_n;
  cyc_kind_e         kind;
  logic [LANES-1:0]  lane_we;
  logic              wr;
  logic              rd;
  logic              burst_act;
  logic [ADDR_W-1:0] cyc_addr;
  logic              q_vld;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign core_rst_n = rst_sync_q[1];

  bsc_decode #(.LANES(LANES)) u_decode (
    .clk(clk), .rst_n(core_rst_n),
    .proc_stb_n(proc_stb_n), .ctl_stb_n(ctl_stb_n), .step_n(step_n),
    .chip_en_n(chip_en_n), .sel_hi(sel_hi), .sel_lo_n(sel_lo_n),
    .all_wr_n(all_wr_n), .lane_gate_n(lane_gate_n), .lane_wr_n(lane_wr_n),
    .burst_act(burst_act), .kind(kind), .lane_we(lane_we), .wr(wr), .rd(rd)
  );

  bsc_burst #(.ADDR_W(ADDR_W)) u_burst (
    .clk(clk), .rst_n(core_rst_n), .kind(kind), .addr_i(addr_i),
    .order_xor(order_xor), .burst_act(burst_act), .cyc_addr(cyc_addr)
  );

  bsc_array #(.ADDR_W(ADDR_W), .LANES(LANES)) u_array (
    .clk(clk), .rst_n(core_rst_n), .addr(cyc_addr), .lane_we(lane_we),
    .wdata(wdata), .rd(rd), .q(rdata), .q_vld(q_vld)
  );

  assign rdata_oe = q_vld && !out_en_n;

  assert_oe_gate_R10: assert property (@(posedge clk) disable iff (!core_rst_n)
    out_en_n |-> !rdata_oe);

  assert_write_slot_R10: assert property (@(posedge clk) disable iff (!core_rst_n)
    wr |=> ##1 !rdata_oe);

  assert_desel_slot_R11: assert property (@(posedge clk) disable iff (!core_rst_n)
    (kind == CYC_DESEL) |=> ##1 !rdata_oe);

  assert_read_slot_R9: assert property (@(posedge clk) disable iff (!core_rst_n)
    rd |=> ##1 (rdata_oe || out_en_n));

endmodule

// File: tb/burst_sram_core_bench.sv
module burst_sram_core_bench;
  localparam int AW = 5;
  localparam int LN = 4;
  localparam int W  = 9 * LN;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [AW-1:0] addr_i;
  logic          proc_stb_n, ctl_stb_n, step_n, chip_en_n, sel_hi, sel_lo_n;
  logic          all_wr_n, lane_gate_n, order_xor, out_en_n;
  logic [LN-1:0] lane_wr_n;
  logic [W-1:0]  wdata;
  logic [W-1:0]  rdata;
  logic          rdata_oe;

  int total = 0;
  int bad   = 0;
  logic [W-1:0] model [1 << AW];

  always #4 clk = ~clk;

  burst_sram_core #(.ADDR_W(AW), .LANES(LN)) u_burst_sram_core (
    .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .proc_stb_n(proc_stb_n),
    .ctl_stb_n(ctl_stb_n), .step_n(step_n), .chip_en_n(chip_en_n),
    .sel_hi(sel_hi), .sel_lo_n(sel_lo_n), .all_wr_n(all_wr_n),
    .lane_gate_n(lane_gate_n), .lane_wr_n(lane_wr_n), .order_xor(order_xor),
    .out_en_n(out_en_n), .wdata(wdata), .rdata(rdata), .rdata_oe(rdata_oe)
  );

  function automatic logic [W-1:0] pat(input int i);
    return {4'(i ^ 5), 32'(i * 32'h01030507 + 32'h5A5A0000)};
  endfunction

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic idle_in();
    proc_stb_n = 1; ctl_stb_n = 1; step_n = 1;
    chip_en_n = 0; sel_hi = 1; sel_lo_n = 0;
    all_wr_n = 1; lane_gate_n = 1; lane_wr_n = '1;
    out_en_n = 0;
  endtask

  task automatic nop();
    idle_in(); step();
  endtask

  task automatic wr_all(input int a, input logic [W-1:0] d);
    idle_in(); ctl_stb_n = 0; all_wr_n = 0; addr_i = AW'(a); wdata = d; step();
    model[a] = d;
  endtask

  task automatic rd_start(input int a);
    idle_in(); proc_stb_n = 0; addr_i = AW'(a); step();
  endtask

  task automatic rd_expect(input int a, input string tag);
    rd_start(a); nop();
    chk({tag, " oe"}, W'(rdata_oe), W'(1));
    chk({tag, " data"}, rdata, model[a]);
  endtask

  task automatic t_reset();
    chk("R12 oe after reset", W'(rdata_oe), W'(0));
    nop();
    chk("R12 no read without burst", W'(rdata_oe), W'(0));
  endtask

  task automatic t_basic();
    for (int i = 0; i < 8; i++) wr_all(i, pat(i));
    rd_start(3);
    chk("R9 not before edge k+1", W'(rdata_oe), W'(0));
    nop();
    chk("R9 data after edge k+1", rdata, model[3]);
    for (int i = 0; i < 8; i += 3) rd_expect(i, "R13 R4 readback");
  endtask

  task automatic t_lanes();
    logic [W-1:0] m;
    wr_all(10, pat(10));
    m = '0;
    m[0 +: 8] = 8'hFF; m[16 +: 8] = 8'hFF; m[32] = 1'b1; m[34] = 1'b1;
    idle_in(); ctl_stb_n = 0; lane_gate_n = 0; lane_wr_n = 4'b1010;
    addr_i = 10; wdata = ~pat(10); step();
    model[10] = (pat(10) & ~m) | (~pat(10) & m);
    rd_expect(10, "R6 R5 two lanes");
    idle_in(); ctl_stb_n = 0; lane_gate_n = 1; lane_wr_n = 4'b0000;
    addr_i = 10; wdata = 36'h0; step();
    nop();
    chk("R4 gated lanes read oe", W'(rdata_oe), W'(1));
    chk("R5 gate blocks lanes", rdata, model[10]);
    idle_in(); ctl_stb_n = 0; all_wr_n = 0; lane_gate_n = 0; lane_wr_n = 4'b1110;
    addr_i = 10; wdata = pat(77); step();
    model[10] = pat(77);
    rd_expect(10, "R5 global overrides");
  endtask

  task automatic t_proc();
    wr_all(11, pat(11));
    wr_all(12, pat(12));
    wr_all(13, pat(13));
    order_xor = 0;
    idle_in(); proc_stb_n = 0; all_wr_n = 0; addr_i = 11; wdata = 36'h0; step();
    nop();
    chk("R3 proc start reads", rdata, pat(11));
    idle_in(); proc_stb_n = 0; addr_i = 12; step();
    idle_in(); step_n = 0; all_wr_n = 0; wdata = pat(99); step();
    model[13] = pat(99);
    rd_expect(12, "R3 base untouched");
    rd_expect(13, "R3 write obeyed next cycle");
  endtask

  task automatic t_linear();
    order_xor = 0;
    idle_in(); ctl_stb_n = 0; all_wr_n = 0; addr_i = 17; wdata = pat(40); step();
    model[17] = pat(40);
    for (int k = 1; k <= 4; k++) begin
      int a;
      a = 16 + ((1 + k) % 4);
      idle_in(); step_n = 0; all_wr_n = 0; wdata = pat(40 + k); step();
      model[a] = pat(40 + k);
    end
    for (int a = 16; a < 20; a++) rd_expect(a, "R7 R13 linear burst");
  endtask

  task automatic t_xor();
    for (int a = 20; a < 24; a++) wr_all(a, pat(a + 100));
    order_xor = 1;
    rd_start(22);
    idle_in(); step_n = 0; step();
    chk("R7 xor first", rdata, model[22]);
    idle_in(); step_n = 0; step();
    chk("R7 xor second", rdata, model[23]);
    idle_in(); step_n = 0; step();
    chk("R7 xor third", rdata, model[20]);
    idle_in(); step_n = 0; step();
    chk("R7 xor fourth", rdata, model[21]);
    nop();
    chk("R7 xor wraps to base", rdata, model[22]);
    order_xor = 0;
  endtask

  task automatic t_pause();
    for (int a = 24; a < 28; a++) wr_all(a, pat(a + 200));
    rd_start(24);
    nop();
    chk("R8 start data", rdata, model[24]);
    idle_in(); step_n = 0; step();
    chk("R8 pause repeats", rdata, model[24]);
    nop();
    chk("R8 step moves", rdata, model[25]);
    nop();
    chk("R8 pause after step", rdata, model[25]);
  endtask

  task automatic t_gating();
    for (int a = 28; a < 32; a++) wr_all(a, pat(a + 300));
    rd_start(28);
    idle_in(); chip_en_n = 1; proc_stb_n = 0; step_n = 0; step();
    chk("R2 start data", rdata, model[28]);
    nop();
    chk("R2 proc strobe ignored, burst stepped", rdata, model[29]);
    idle_in(); chip_en_n = 1; ctl_stb_n = 0; step();
    chk("R11 slot before deselect", W'(rdata_oe), W'(1));
    idle_in(); step_n = 0; all_wr_n = 0; wdata = 36'h0; step();
    chk("R11 R2 off after deselect", W'(rdata_oe), W'(0));
    rd_expect(30, "R8 inactive cycle wrote nothing");
    rd_expect(29, "R8 inactive cycle wrote nothing");
  endtask

  task automatic t_select();
    idle_in(); sel_hi = 0; ctl_stb_n = 0; all_wr_n = 0; addr_i = 0; wdata = 36'h0; step();
    idle_in(); sel_lo_n = 1; proc_stb_n = 0; addr_i = 1; step();
    chk("R1 no drive after unselected strobe", W'(rdata_oe), W'(0));
    nop();
    chk("R1 still off", W'(rdata_oe), W'(0));
    rd_expect(0, "R1 no write while unselected");
  endtask

  task automatic t_oe();
    rd_start(5);
    idle_in(); out_en_n = 1; step();
    chk("R10 oe high forces off", W'(rdata_oe), W'(0));
    out_en_n = 0; #1;
    chk("R10 oe low async", W'(rdata_oe), W'(1));
    chk("R10 data under oe", rdata, model[5]);
    rd_start(6);
    wr_all(7, pat(177));
    chk("R9 read slot before write", W'(rdata_oe), W'(1));
    idle_in(); chip_en_n = 1; ctl_stb_n = 0; step();
    chk("R10 write slot off", W'(rdata_oe), W'(0));
    rd_expect(7, "R13 write landed");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 0; order_xor = 0; addr_i = '0; wdata = '0;
    idle_in();
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    t_reset();
    t_basic();
    t_lanes();
    t_proc();
    t_linear();
    t_xor();
    t_pause();
    t_gating();
    t_select();
    t_oe();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule